// File: doc/BRIEF.md
# Serial Crosspoint Configuration Loader

This block takes the routing setup for a nine-output crosspoint switch from a slow serial port and drives the switch control lines. For each output it gives an enable flag and a 4-bit code that picks the input routed there. A complete configuration is one 45-bit frame. Each output owns a 5-bit field: the enable flag travels first, then the select code from its most significant bit down. The field for the highest-numbered output arrives first.

All port inputs are asynchronous to the system clock. They pass through a synchronizer, and the shifter detects falling edges of the serial clock in the system clock domain. A shift takes place only when chip select is low, the serial/parallel select is low and the parallel write clock is high. A bank of update registers sits between the shift register and the outputs. While the update control is high, the bank holds the last configuration. While the control is low, the bank copies the shift register on every system clock, so every partly shifted state reaches the switch.

Top module: `xpt_serial_loader`

## Requirements
- R1: The shift register advances only on a falling edge of `sclk`. A rising edge leaves every output unchanged.
- R2: After 45 shifts, the k-th bit shifted in lands at frame bit 44-k. Output j reads its enable from frame bit 5j+4 onto `en_o[j]`, and its select from frame bits 5j+3..5j onto `sel_o[4j+3:4j]`, with frame bit 5j+3 as the select MSB. The first field shifted in therefore controls output 8.
- R3: While `cs_n` is high, serial clock edges shift nothing.
- R4: While `par_sel` is high (parallel mode), serial clock edges shift nothing.
- R5: While `wr_clk` is low, serial clock edges shift nothing.
- R6: While `latch_hold` is high, `en_o` and `sel_o` keep their value, even while bits are being shifted.
- R7: While `latch_hold` is low, `en_o` and `sel_o` follow the shift register after every shift, including partial frames.
- R8: Synchronous active-high `rst` clears the frame. Once it is released, every output is disabled and every select code is 0.
- R9: Shifting more than 45 bits discards the oldest bits. Only the last 45 bits form the frame.
- R10: With `latch_hold` low, a falling `sclk` edge shows on the outputs exactly 4 `clk` rising edges after it is applied. The outputs still show the old value after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; opens the serial port |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdata | input | 1 | Serial data |
| par_sel | input | 1 | Mode select; low selects serial loading |
| wr_clk | input | 1 | Parallel write clock; must be high for serial shifting |
| latch_hold | input | 1 | High holds the outputs; low lets them follow the shift register |
| en_o | output | 9 | Per-output enable, bit j for output j |
| sel_o | output | 36 | Per-output input select, 4 bits per output, output j at [4j+3:4j] |

## Verification
The bench loads random and directed frames and tests field ordering against an independent bit-position model. A design with a reversed field or bit order would route the wrong input to the wrong output. Checks after every few bits while the outputs are held catch a hold that leaks partial frames. A run of bit-by-bit checks with the outputs open catches a design that updates only on full frames. The bench also feeds serial clocks with chip select, mode select or write clock blocking and expects no change; a missing gate would corrupt the stored frame. An exact-cycle check on one edge catches an extra or missing pipeline stage, and an over-length frame catches a shifter that saturates or wraps instead of dropping old bits.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  // Default geometry of the crosspoint control word
  localparam int unsigned XPT_OUTPUTS = 9;
  localparam int unsigned XPT_SEL_W   = 4;
  localparam int unsigned XPT_SYNC    = 2;
endpackage

// File: rtl/xpt_in_sync.sv
module xpt_in_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned DEPTH   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/xpt_frame_shifter.sv
module xpt_frame_shifter #(
  parameter int unsigned FRAME_W = 45
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sdata_s,
  input  logic               gate_open,
  output logic [FRAME_W-1:0] frame_q
);
  logic sclk_prev;
  logic fall;
  logic shift;

  assign fall  = sclk_prev & ~sclk_s;
  assign shift = fall & gate_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b1;
      frame_q   <= '0;
    end else begin
      sclk_prev <= sclk_s;
      if (shift) frame_q <= {frame_q[FRAME_W-2:0], sdata_s};
    end
  end

  // R3 R4 R5
  closed_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_open |=> $stable(frame_q));

  // R1
  no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(sclk_prev && !sclk_s) |=> $stable(frame_q));

  // R1
  single_fall_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/xpt_update_bank.sv
module xpt_update_bank #(
  parameter int unsigned N_OUT = 9,
  parameter int unsigned SEL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hold_s,
  input  logic [N_OUT*(SEL_W+1)-1:0] frame,
  output logic [N_OUT-1:0]         en_o,
  output logic [N_OUT*SEL_W-1:0]   sel_o
);
  localparam int unsigned FIELD_W = SEL_W + 1;
  localparam int unsigned FRAME_W = N_OUT * FIELD_W;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic             en_r;
    logic [SEL_W-1:0] sel_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r  <= 1'b0;
        sel_r <= '0;
      end else if (!hold_s) begin
        en_r  <= frame[k*FIELD_W + SEL_W];
        sel_r <= frame[k*FIELD_W +: SEL_W];
      end
    end

    assign en_o[k]                = en_r;
    assign sel_o[k*SEL_W +: SEL_W] = sel_r;
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    hold_s |=> ($stable(en_o) && $stable(sel_o)));

  // R7
  follow_top_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> (en_o[N_OUT-1] == $past(frame[FRAME_W-1])));

  // R7
  follow_low_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> (sel_o[SEL_W-1:0] == $past(frame[SEL_W-1:0])));
endmodule

// File: rtl/xpt_serial_loader.sv
module xpt_serial_loader
  import xpt_cfg_pkg::*;
#(
  parameter int unsigned N_OUT      = XPT_OUTPUTS,
  parameter int unsigned SEL_W      = XPT_SEL_W,
  parameter int unsigned SYNC_DEPTH = XPT_SYNC
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdata,
  input  logic                   par_sel,
  input  logic                   wr_clk,
  input  logic                   latch_hold,
  output logic [N_OUT-1:0]       en_o,
  output logic [N_OUT*SEL_W-1:0] sel_o
);
  localparam int unsigned FIELD_W = SEL_W + 1;
  localparam int unsigned FRAME_W = N_OUT * FIELD_W;
  localparam int unsigned CTL_W   = 6;
  // idle levels: hold high, write clock high, serial mode, data 0, sclk high, deselected
  localparam logic [CTL_W-1:0] CTL_IDLE = 6'b110011;

  logic [CTL_W-1:0]   ctl_raw;
  logic [CTL_W-1:0]   ctl_s;
  logic               gate_open;
  logic [FRAME_W-1:0] frame;

  assign ctl_raw = {latch_hold, wr_clk, par_sel, sdata, sclk, cs_n};

  xpt_in_sync #(
    .W      (CTL_W),
    .DEPTH  (SYNC_DEPTH),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (ctl_raw),
    .q  (ctl_s)
  );

  assign gate_open = ~ctl_s[0] & ~ctl_s[3] & ctl_s[4];

  xpt_frame_shifter #(
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (ctl_s[1]),
    .sdata_s  (ctl_s[2]),
    .gate_open(gate_open),
    .frame_q  (frame)
  );

  xpt_update_bank #(
    .N_OUT(N_OUT),
    .SEL_W(SEL_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .hold_s(ctl_s[5]),
    .frame (frame),
    .en_o  (en_o),
    .sel_o (sel_o)
  );

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_o == '0 && sel_o == '0));
endmodule

// File: tb/sim_xpt_serial_loader.sv
`timescale 1ns/1ps
module sim_xpt_serial_loader;
  logic clk = 1'b0;
  logic rst, cs_n, sclk, sdata, par_sel, wr_clk, latch_hold;
  logic [8:0]  en_o;
  logic [35:0] sel_o;

  always #4 clk = ~clk;

  xpt_serial_loader u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .par_sel(par_sel), .wr_clk(wr_clk), .latch_hold(latch_hold),
    .en_o(en_o), .sel_o(sel_o)
  );

  typedef struct {
    int          due;
    logic [8:0]  en;
    logic [35:0] sel;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [44:0] m_sr;
  logic [8:0]  m_en;
  logic [35:0] m_sel;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] map_en(logic [44:0] f);
    logic [8:0] r;
    for (int k = 0; k < 9; k++) r[k] = f[5*k+4];
    return r;
  endfunction

  function automatic logic [35:0] map_sel(logic [44:0] f);
    logic [35:0] r;
    for (int k = 0; k < 9; k++) r[4*k +: 4] = f[5*k +: 4];
    return r;
  endfunction

  // monitor: pops expectations when due and compares
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (e.due != cyc) begin
        n_fail++;
        $display("FAIL %s: check missed at cycle %0d, expected cycle %0d", e.tag, cyc, e.due);
      end else if (en_o !== e.en || sel_o !== e.sel) begin
        n_fail++;
        $display("FAIL %s: en=%h sel=%h expected en=%h sel=%h", e.tag, en_o, sel_o, e.en, e.sel);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic push(string tag, int delay);
    exp_t e;
    e.due = cyc + delay;
    e.en  = m_en;
    e.sel = m_sel;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    #2;
  endtask

  task automatic check(string tag);
    push(tag, 1);
    drain();
  endtask

  function automatic bit gate();
    return !cs_n && !par_sel && wr_clk;
  endfunction

  task automatic refresh();
    if (!latch_hold) begin
      m_en  = map_en(m_sr);
      m_sel = map_sel(m_sr);
    end
  endtask

  task automatic send_bit(logic b);
    sdata = b;
    tick(3);
    sclk = 1'b0;
    if (gate()) m_sr = {m_sr[43:0], b};
    refresh();
    tick(5);
    sclk = 1'b1;
    tick(5);
  endtask

  task automatic set_hold(logic v);
    latch_hold = v;
    refresh();
    tick(5);
  endtask

  task automatic load_frame(logic [44:0] f, string tag);
    for (int i = 0; i < 45; i++) begin
      send_bit(f[44-i]);
      if (i % 9 == 8) check("R6 outputs held while shifting");
    end
    set_hold(1'b0);
    check(tag);
    set_hold(1'b1);
  endtask

  function automatic logic [44:0] rand_frame();
    logic [44:0] f;
    for (int i = 0; i < 45; i++) f[i] = $urandom_range(0, 1);
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [44:0] f;
    logic [8:0]  old_en;
    logic [35:0] old_sel;
    logic        b;

    rst = 1'b1; cs_n = 1'b1; sclk = 1'b1; sdata = 1'b0;
    par_sel = 1'b0; wr_clk = 1'b1; latch_hold = 1'b1;
    m_sr = '0; m_en = '0; m_sel = '0;
    tick(5);
    rst = 1'b0;
    tick(2);
    check("R8 reset state");

    cs_n = 1'b0;
    tick(3);

    // R2: random frames and a directed frame
    load_frame(rand_frame(), "R2 random frame mapping");
    f = '0;
    for (int k = 0; k < 9; k++) begin
      f[5*k+4]    = k[0];
      f[5*k +: 4] = k[3:0];
    end
    load_frame(f, "R2 directed frame mapping");
    load_frame(rand_frame(), "R2 second random frame");

    // R7: outputs track every shift when the hold is released
    set_hold(1'b0);
    for (int i = 0; i < 10; i++) begin
      send_bit(1'($urandom_range(0, 1)));
      check("R7 outputs track partial frame");
    end

    // R10 exact latency, then R1 rising edge has no effect
    b = ~m_sr[0];
    sdata = b;
    tick(3);
    sclk = 1'b0;
    old_en = m_en; old_sel = m_sel;
    push("R10 old value after third edge", 3);
    m_sr = {m_sr[43:0], b};
    refresh();
    push("R10 new value after fourth edge", 4);
    if (old_en == m_en && old_sel == m_sel) $display("note: latency step showed no output change");
    drain();
    tick(3);
    sclk = 1'b1;
    tick(6);
    check("R1 rising edge ignored");

    // R3: deselected
    cs_n = 1'b1;
    tick(3);
    for (int i = 0; i < 5; i++) send_bit(~m_sr[0]);
    check("R3 chip select high blocks shifting");
    cs_n = 1'b0;
    tick(3);

    // R4: parallel mode
    par_sel = 1'b1;
    tick(3);
    for (int i = 0; i < 5; i++) send_bit(~m_sr[0]);
    check("R4 parallel mode blocks shifting");
    par_sel = 1'b0;
    tick(3);

    // R5: write clock low
    wr_clk = 1'b0;
    tick(3);
    for (int i = 0; i < 5; i++) send_bit(~m_sr[0]);
    check("R5 write clock low blocks shifting");
    wr_clk = 1'b1;
    tick(3);

    // R9: over-length frame keeps only the last 45 bits
    set_hold(1'b1);
    f = rand_frame();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    for (int i = 0; i < 45; i++) send_bit(f[44-i]);
    set_hold(1'b0);
    check("R9 last 45 bits form the frame");
    if (m_sr != f) $display("note: model frame differs from loaded frame");

    // R8: reset after a loaded frame
    rst = 1'b1;
    m_sr = '0; m_en = '0; m_sel = '0;
    tick(3);
    rst = 1'b0;
    tick(2);
    check("R8 reset clears loaded frame");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule